// File: doc/BRIEF.md
# I2C Register-Port Target with Busy Refusal

This block is the serial front end of a register space on an I2C bus. It oversamples SCL and SDA on the system clock. It finds START, REPEATED START and STOP conditions and compares the incoming address byte with its own identity. The identity is a fixed four-bit device code, two strap pins and a bit that is ignored. After an accepted write address, the first byte sets the register pointer and each later byte is written through a one-cycle strobe. The pointer advances after every byte. To read, the controller writes the pointer, issues a REPEATED START and sends the address with the direction bit set. The block then shifts out register bytes MSB first until the controller answers with NACK.

Two inputs from the register logic decide whether the block acknowledges. A busy input makes the block refuse its own address. A legality input, evaluated on the pointer the block presents, makes it refuse a command byte. After any refusal the block stays silent until the next START or STOP. A STOP at any bit position returns the block to idle. A STOP that falls in the same SCL high period as the START before it is ignored.

Top module: `i2c_busy_target`

## Requirements
- R1: While reset is asserted and after its release, sda_oe is 0, reg_wr_en and reg_rd_en are 0 and reg_addr is 0.
- R2: An address byte is own when bits 7..4 are 1010 and bits 3..2 equal strap_i[1:0]. Bit 1 is ignored and bit 0 selects read (1) or write (0). A byte that is not own gets no ACK, and the block stays silent for the rest of that transfer.
- R3: The block acknowledges an accepted address, command or write-data byte by setting sda_oe to 1 during the 9th SCL clock of that byte. It releases the line after that clock's falling edge.
- R4: If busy_i is 1 when the 9th clock of an own address begins, the block answers NACK and writes no register in that transfer.
- R5: The command byte appears on reg_addr after its 8th SCL rising edge. If reg_illegal_i is 1 when the 9th clock begins, the block answers NACK and ignores the following data bytes (no ACK, no write).
- R6: Each write-data byte produces a one-cycle reg_wr_en with reg_addr and reg_wr_data valid, during that byte's ACK. reg_addr then increments by one for the next byte.
- R7: After command write, REPEATED START and own address with bit 0 = 1, the block sends the byte from reg_rd_data, which is read combinationally at reg_addr, MSB first. A controller ACK advances reg_addr and sends the next byte. A NACK releases SDA until START or STOP. Each byte fetched gives one reg_rd_en pulse.
- R8: A STOP at any bit position returns the block to idle with SDA released, and a partially received data byte is not written.
- R9: An SDA rise during the same SCL high period as a START is not taken as a STOP, and the transfer continues.
- R10: Back-to-back write transfers are accepted whether a REPEATED START or a STOP and START separates them.
- R11: sda_oe changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| strap_i | input | 2 | Strapped address bits 3..2 |
| busy_i | input | 1 | Register logic busy; refuse own address |
| reg_addr | output | 8 | Register pointer |
| reg_illegal_i | input | 1 | reg_addr is not a legal register |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wr_data | output | 8 | Write data |
| reg_rd_en | output | 1 | One-cycle read strobe |
| reg_rd_data | input | 8 | Read data for reg_addr, combinational |

## Verification
The properties assume a controller that changes SDA only while SCL is low, apart from START and STOP. They also assume SCL phases much longer than the synchroniser latency, and a controller that never tries a START or STOP while the target holds SDA low. The bench drives every SDA change with SCL low and keeps each SCL phase at least eight system clocks long. It changes busy_i only between transfers, and it computes reg_illegal_i and reg_rd_data directly from reg_addr. Transfers that end early stop only at points where the target has released the line.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_WDATA,
    ST_RDATA,
    ST_WAIT
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain_q, chain_d;
  logic              last_q;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
      last_q  <= RST_VAL;
    end else begin
      chain_q <= chain_d;
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign q    = chain_q[STAGES-1];
  assign rise = q & ~last_q;
  assign fall = ~q & last_q;
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_q,
  input  logic scl_rise,
  input  logic scl_fall,
  input  logic sda_rise,
  input  logic sda_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic armed_q, armed_d;
  logic scl_held;

  assign scl_held = scl_q & ~scl_rise;
  assign start_ev = scl_held & sda_fall;
  assign stop_ev  = scl_held & sda_rise & armed_q;

  // A STOP counts only after an SCL pulse has followed the last START.
  always_comb begin
    armed_d = armed_q;
    if (start_ev)      armed_d = 1'b0;
    else if (scl_fall) armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b1;
    else        armed_q <= armed_d;
  end
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
#(
  parameter logic [3:0] DEV_ID = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_q,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic [1:0] strap,
  input  logic       busy,
  input  logic       addr_bad,
  input  byte_t      rd_data,
  output logic       sda_oe,
  output byte_t      reg_addr,
  output logic       wr_en,
  output byte_t      wr_data,
  output logic       rd_en,
  output logic       idle
);
  localparam int               CNT_W   = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST    = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_M1 = CNT_W'(BYTE_W - 1);

  tgt_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ninth_q, ninth_d;
  byte_t            shift_q, shift_d;
  byte_t            tx_q, tx_d;
  byte_t            addr_q, addr_d;
  byte_t            wdat_q, wdat_d;
  logic             oe_q, oe_d;
  logic             mack_q, mack_d;
  logic             wr_q, wr_d;
  logic             rd_q, rd_d;
  logic             active;
  logic             own;

  assign active = (state_q == ST_ADDR) || (state_q == ST_CMD) ||
                  (state_q == ST_WDATA) || (state_q == ST_RDATA);
  assign own    = (shift_q[7:4] == DEV_ID) && (shift_q[3:2] == strap);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    ninth_d = ninth_q;
    shift_d = shift_q;
    tx_d    = tx_q;
    addr_d  = addr_q;
    wdat_d  = wdat_q;
    oe_d    = oe_q;
    mack_d  = mack_q;
    wr_d    = 1'b0;
    rd_d    = 1'b0;
    if (start_ev) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      ninth_d = 1'b0;
      oe_d    = 1'b0;
    end else if (stop_ev) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      ninth_d = 1'b0;
      oe_d    = 1'b0;
    end else if (active) begin
      if (scl_rise) begin
        if (!ninth_q) begin
          if (cnt_q != LAST) begin
            shift_d = {shift_q[BYTE_W-2:0], sda_q};
            cnt_d   = cnt_q + 1'b1;
            if (state_q == ST_CMD && cnt_q == LAST_M1)
              addr_d = {shift_q[BYTE_W-2:0], sda_q};
          end
        end else if (state_q == ST_RDATA) begin
          mack_d = ~sda_q;
          if (!sda_q) addr_d = addr_q + 1'b1;
        end
      end else if (scl_fall) begin
        if (ninth_q) begin
          // end of the acknowledge clock
          ninth_d = 1'b0;
          cnt_d   = '0;
          oe_d    = 1'b0;
          unique case (state_q)
            ST_ADDR: begin
              if (shift_q[0]) begin
                state_d = ST_RDATA;
                tx_d    = rd_data;
                oe_d    = ~rd_data[BYTE_W-1];
                rd_d    = 1'b1;
              end else begin
                state_d = ST_CMD;
              end
            end
            ST_CMD:   state_d = ST_WDATA;
            ST_WDATA: addr_d  = addr_q + 1'b1;
            ST_RDATA: begin
              if (mack_q) begin
                tx_d = rd_data;
                oe_d = ~rd_data[BYTE_W-1];
                rd_d = 1'b1;
              end else begin
                state_d = ST_WAIT;
              end
            end
            default: state_d = ST_WAIT;
          endcase
        end else if (cnt_q == LAST) begin
          // start of the acknowledge clock
          ninth_d = 1'b1;
          unique case (state_q)
            ST_ADDR: begin
              if (own && !busy) begin
                oe_d = 1'b1;
              end else begin
                state_d = ST_WAIT;
                ninth_d = 1'b0;
              end
            end
            ST_CMD: begin
              if (addr_bad) begin
                state_d = ST_WAIT;
                ninth_d = 1'b0;
              end else begin
                oe_d = 1'b1;
              end
            end
            ST_WDATA: begin
              oe_d   = 1'b1;
              wr_d   = 1'b1;
              wdat_d = shift_q;
            end
            ST_RDATA: oe_d = 1'b0;
            default:  state_d = ST_WAIT;
          endcase
        end else if (state_q == ST_RDATA && cnt_q != '0) begin
          oe_d = ~tx_q[BYTE_W-2];
          tx_d = {tx_q[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ninth_q <= 1'b0;
      shift_q <= '0;
      tx_q    <= '0;
      addr_q  <= '0;
      wdat_q  <= '0;
      oe_q    <= 1'b0;
      mack_q  <= 1'b0;
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ninth_q <= ninth_d;
      shift_q <= shift_d;
      tx_q    <= tx_d;
      addr_q  <= addr_d;
      wdat_q  <= wdat_d;
      oe_q    <= oe_d;
      mack_q  <= mack_d;
      wr_q    <= wr_d;
      rd_q    <= rd_d;
    end
  end

  assign sda_oe   = oe_q;
  assign reg_addr = addr_q;
  assign wr_en    = wr_q;
  assign wr_data  = wdat_q;
  assign rd_en    = rd_q;
  assign idle     = (state_q == ST_IDLE);
endmodule

// File: rtl/i2c_busy_target.sv
module i2c_busy_target
  import i2c_tgt_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_ID      = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [1:0] strap_i,
  input  logic       busy_i,
  output logic [7:0] reg_addr,
  input  logic       reg_illegal_i,
  output logic       reg_wr_en,
  output logic [7:0] reg_wr_data,
  output logic       reg_rd_en,
  input  logic [7:0] reg_rd_data
);
  localparam int N_LINES = 2;

  logic [1:0]         rst_pipe_q;
  logic               rst_int_n;
  logic [N_LINES-1:0] line_raw, line_q, line_rise, line_fall;
  logic               start_ev, stop_ev;
  logic               eng_idle;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  assign line_raw = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    i2c_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk  (clk),
      .rst_n(rst_int_n),
      .d    (line_raw[g]),
      .q    (line_q[g]),
      .rise (line_rise[g]),
      .fall (line_fall[g])
    );
  end

  i2c_cond_detect u_cond (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .scl_q   (line_q[0]),
    .scl_rise(line_rise[0]),
    .scl_fall(line_fall[0]),
    .sda_rise(line_rise[1]),
    .sda_fall(line_fall[1]),
    .start_ev(start_ev),
    .stop_ev (stop_ev)
  );

  i2c_tgt_engine #(.DEV_ID(DEV_ID)) u_eng (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .scl_rise(line_rise[0]),
    .scl_fall(line_fall[0]),
    .sda_q   (line_q[1]),
    .start_ev(start_ev),
    .stop_ev (stop_ev),
    .strap   (strap_i),
    .busy    (busy_i),
    .addr_bad(reg_illegal_i),
    .rd_data (reg_rd_data),
    .sda_oe  (sda_oe),
    .reg_addr(reg_addr),
    .wr_en   (reg_wr_en),
    .wr_data (reg_wr_data),
    .rd_en   (reg_rd_en),
    .idle    (eng_idle)
  );
endmodule

// File: rtl/i2c_busy_target_chk.sv
module i2c_busy_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_oe,
  input logic reg_wr_en,
  input logic reg_rd_en,
  input logic eng_idle
);
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);                                   // R11
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en);                                       // R6
  AST_WR_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> sda_oe);                                           // R3
  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |=> !reg_rd_en);                                       // R7
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && reg_rd_en));                                      // R7
  AST_IDLE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_idle |-> !sda_oe);                                           // R8
endmodule

bind i2c_busy_target i2c_busy_target_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_i    (scl_i),
  .sda_oe   (sda_oe),
  .reg_wr_en(reg_wr_en),
  .reg_rd_en(reg_rd_en),
  .eng_idle (eng_idle)
);

// File: tb/tb_i2c_busy_target.sv
module tb_i2c_busy_target;
  localparam int Q = 8;
  localparam int H = 16;

  typedef struct packed {
    logic [7:0] abyte;
    logic [7:0] cmd;
    logic [7:0] data;
    logic       busy;
    logic       a_ack;
    logic       c_ack;
    logic       w_ok;
  } vec_t;

  // strap = 2'b10 -> own write address 1010_10x0
  localparam vec_t VECS [0:7] = '{
    '{8'hA8, 8'h05, 8'h3C, 1'b0, 1'b1, 1'b1, 1'b1},
    '{8'hAA, 8'h06, 8'hC3, 1'b0, 1'b1, 1'b1, 1'b1},
    '{8'hAC, 8'h07, 8'h11, 1'b0, 1'b0, 1'b0, 1'b0},
    '{8'hA8, 8'h08, 8'h22, 1'b1, 1'b0, 1'b0, 1'b0},
    '{8'hA8, 8'hF3, 8'h33, 1'b0, 1'b1, 1'b0, 1'b0},
    '{8'hB8, 8'h09, 8'h44, 1'b0, 1'b0, 1'b0, 1'b0},
    '{8'hA8, 8'h00, 8'hFF, 1'b0, 1'b1, 1'b1, 1'b1},
    '{8'h28, 8'h0A, 8'h55, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_ctl = 1'b1;
  logic       busy = 1'b0;
  logic       sda_oe;
  logic [7:0] reg_addr, reg_wr_data;
  logic       reg_wr_en, reg_rd_en;
  wire        sda_line = sda_ctl & ~sda_oe;
  wire        illegal  = (reg_addr >= 8'hF0);
  wire [7:0]  rd_data  = reg_addr ^ 8'h5A;

  int n_tests = 0;
  int n_fail  = 0;
  int wr_cnt  = 0;
  int rd_cnt  = 0;
  int oe_viol = 0;
  logic [7:0] last_wa = '0, last_wd = '0;
  logic       oe_prev = 1'b0;
  logic       done = 1'b0;

  always #2.5 clk = ~clk;

  i2c_busy_target dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (scl),
    .sda_i        (sda_line),
    .sda_oe       (sda_oe),
    .strap_i      (2'b10),
    .busy_i       (busy),
    .reg_addr     (reg_addr),
    .reg_illegal_i(illegal),
    .reg_wr_en    (reg_wr_en),
    .reg_wr_data  (reg_wr_data),
    .reg_rd_en    (reg_rd_en),
    .reg_rd_data  (rd_data)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (reg_wr_en) begin
        wr_cnt  <= wr_cnt + 1;
        last_wa <= reg_addr;
        last_wd <= reg_wr_data;
      end
      if (reg_rd_en) rd_cnt <= rd_cnt + 1;
      if (sda_oe != oe_prev && scl) oe_viol <= oe_viol + 1;
    end
    oe_prev <= sda_oe;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_ctl = 1'b1; wait_clk(Q);
    scl = 1'b1;     wait_clk(Q);
    sda_ctl = 1'b0; wait_clk(Q);
    scl = 1'b0;     wait_clk(Q);
  endtask

  task automatic bus_stop();
    sda_ctl = 1'b0; wait_clk(Q);
    scl = 1'b1;     wait_clk(Q);
    sda_ctl = 1'b1; wait_clk(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_ctl = b; wait_clk(Q);
    scl = 1'b1;  wait_clk(H);
    scl = 1'b0;  wait_clk(Q);
  endtask

  task automatic write_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_ctl = 1'b1; wait_clk(Q);
    scl = 1'b1;     wait_clk(H / 2);
    ack = ~sda_line; wait_clk(H / 2);
    scl = 1'b0;     wait_clk(Q);
  endtask

  task automatic read_byte(output logic [7:0] b, input logic mack);
    for (int i = 7; i >= 0; i--) begin
      sda_ctl = 1'b1; wait_clk(Q);
      scl = 1'b1;     wait_clk(H / 2);
      b[i] = sda_line; wait_clk(H / 2);
      scl = 1'b0;     wait_clk(Q);
    end
    send_bit(~mack);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic       ack;
    logic [7:0] rb;
    int         w0;
    int         r0;

    // R1 reset state
    wait_clk(4);
    check("R1 oe in reset", int'(sda_oe), 0);
    check("R1 wr_en in reset", int'(reg_wr_en), 0);
    check("R1 rd_en in reset", int'(reg_rd_en), 0);
    rst_n = 1'b1;
    wait_clk(6);
    check("R1 oe after reset", int'(sda_oe), 0);
    check("R1 addr after reset", int'(reg_addr), 0);

    // table: R2 R3 R4 R5 R6
    for (int i = 0; i < 8; i++) begin
      busy = VECS[i].busy;
      w0 = wr_cnt;
      bus_start();
      write_byte(VECS[i].abyte, ack);
      check($sformatf("R2 addr ack vec%0d", i), int'(ack), int'(VECS[i].a_ack));
      write_byte(VECS[i].cmd, ack);
      check($sformatf("R5 cmd ack vec%0d", i), int'(ack), int'(VECS[i].c_ack));
      write_byte(VECS[i].data, ack);
      check($sformatf("R3 data ack vec%0d", i), int'(ack), int'(VECS[i].w_ok));
      bus_stop();
      busy = 1'b0;
      wait_clk(4);
      check($sformatf("R4 write count vec%0d", i), wr_cnt - w0, int'(VECS[i].w_ok));
      if (VECS[i].w_ok) begin
        check($sformatf("R6 write addr vec%0d", i), int'(last_wa), int'(VECS[i].cmd));
        check($sformatf("R6 write data vec%0d", i), int'(last_wd), int'(VECS[i].data));
      end
    end

    // R6 multi-byte write with pointer increment
    w0 = wr_cnt;
    bus_start();
    write_byte(8'hA8, ack);
    write_byte(8'h20, ack);
    write_byte(8'h11, ack);
    write_byte(8'h22, ack);
    write_byte(8'h33, ack);
    check("R6 third byte ack", int'(ack), 1);
    bus_stop();
    wait_clk(4);
    check("R6 burst count", wr_cnt - w0, 3);
    check("R6 burst last addr", int'(last_wa), 8'h22);
    check("R6 burst last data", int'(last_wd), 8'h33);

    // R7 read after repeated start
    r0 = rd_cnt;
    bus_start();
    write_byte(8'hA8, ack);
    write_byte(8'h40, ack);
    bus_start();
    write_byte(8'hA9, ack);
    check("R7 read addr ack", int'(ack), 1);
    read_byte(rb, 1'b1);
    check("R7 first byte", int'(rb), 8'h40 ^ 8'h5A);
    read_byte(rb, 1'b0);
    check("R7 second byte", int'(rb), 8'h41 ^ 8'h5A);
    read_byte(rb, 1'b1);
    check("R7 released after NACK", int'(rb), 8'hFF);
    bus_stop();
    wait_clk(4);
    check("R7 fetch count", rd_cnt - r0, 2);

    // R10 writes separated by repeated start
    w0 = wr_cnt;
    bus_start();
    write_byte(8'hA8, ack);
    write_byte(8'h50, ack);
    write_byte(8'h01, ack);
    bus_start();
    write_byte(8'hAA, ack);
    check("R10 addr ack after Sr", int'(ack), 1);
    write_byte(8'h51, ack);
    write_byte(8'h02, ack);
    bus_stop();
    wait_clk(4);
    check("R10 write count", wr_cnt - w0, 2);
    check("R10 last addr", int'(last_wa), 8'h51);
    check("R10 last data", int'(last_wd), 8'h02);

    // R8 STOP inside the address byte, then a normal write
    bus_start();
    send_bit(1'b1);
    send_bit(1'b0);
    send_bit(1'b1);
    bus_stop();
    wait_clk(4);
    check("R8 oe after early stop", int'(sda_oe), 0);
    w0 = wr_cnt;
    bus_start();
    write_byte(8'hA8, ack);
    check("R8 ack after early stop", int'(ack), 1);
    write_byte(8'h60, ack);
    for (int b = 0; b < 4; b++) send_bit(b[0]);
    bus_stop();
    wait_clk(4);
    check("R8 no write on partial byte", wr_cnt - w0, 0);
    check("R8 oe after data stop", int'(sda_oe), 0);

    // R9 SDA rise in the START high period is not a STOP
    w0 = wr_cnt;
    sda_ctl = 1'b1; wait_clk(Q);
    scl = 1'b1;     wait_clk(Q);
    sda_ctl = 1'b0; wait_clk(Q);
    sda_ctl = 1'b1; wait_clk(Q);
    scl = 1'b0;     wait_clk(Q);
    write_byte(8'hA8, ack);
    check("R9 addr ack after illegal stop", int'(ack), 1);
    write_byte(8'h70, ack);
    write_byte(8'h9C, ack);
    bus_stop();
    wait_clk(4);
    check("R9 write count", wr_cnt - w0, 1);
    check("R9 write data", int'(last_wd), 8'h9C);

    check("R11 oe changed while SCL high", oe_viol, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule